// File: doc/BRIEF.md
# Framed Stimulus Pattern Generator

This block produces a repeating test pattern from plain clocked logic. A position counter advances once per enabled clock and wraps after 64 positions, so each pass through the positions is one frame. Three registered decoders of that position drive the outputs: a start strobe that marks the first position of a frame, an 8-bit data word that is high on two plateaus with a low gap between them, and a done strobe that marks the last position.

The block is meant to feed a downstream unit under test with a stimulus that repeats exactly, every cycle the same, with no timed waits anywhere. While the enable input is high, frames follow each other with no gap. Dropping the enable freezes the position and quiets every output. Raising it again resumes the frame where it stopped. A synchronous reset returns the position to the start of a frame.

All three outputs are registered. The values seen after a clock edge describe the position the counter held just before that edge.

Top module: `pattern_frame_gen`

## Requirements
- R1: The internal position steps by one on each clock edge where the enable is high and reset is low. It wraps from 63 back to 0, so start pulses are exactly 64 enabled cycles apart when the enable stays high.
- R2: After an enabled edge taken at position 0, start_o is 1 and data_o is 0. start_o is 0 after every other edge, so it is never high on two consecutive cycles.
- R3: After an enabled edge taken at positions 1 to 23, data_o is 8'hFF.
- R4: After an enabled edge taken at positions 24 to 40, data_o is 8'h00.
- R5: After an enabled edge taken at positions 41 to 63, data_o is 8'hFF. data_o only ever shows 8'h00 or 8'hFF.
- R6: done_o is 1 for exactly the cycle after an enabled edge taken at position 63. With the enable held high, the next frame's start_o follows on the very next cycle.
- R7: A clock edge with rst high sets the position to 0 and drives start_o, done_o and data_o to 0. The first enabled edge after reset is released produces the position-0 outputs.
- R8: A clock edge with rst low and en low leaves the position unchanged and drives start_o, done_o and data_o to 0. The next enabled edge continues from the held position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the position |
| start_o | output | 1 | One-cycle strobe for frame position 0 |
| data_o | output | 8 | Pattern data word (all ones or all zeros) |
| done_o | output | 1 | One-cycle strobe for frame position 63 |

## Verification
Some properties are checked on every clock. These are the counter stepping and holding, the single-cycle start strobe, the zero data word under a start, the two legal data values, the quiet outputs while idle or in reset, and a start following each done when enabled. The exact plateau boundaries at positions 23/24 and 40/41 can only be shown by the bench's position-indexed reference model. The same holds for resuming from the held position after a pause, a reset landing mid-frame, and the 64-cycle spacing of start strobes over several back-to-back frames.

// File: rtl/pattern_frame_pkg.sv
package pattern_frame_pkg;

  // Position lies in the high plateaus: not the first slot, not the low gap.
  function automatic logic level_is_high(input int unsigned pos,
                                         input int unsigned gap_first,
                                         input int unsigned gap_last);
    return (pos != 0) && ((pos < gap_first) || (pos > gap_last));
  endfunction

  function automatic logic is_first_slot(input int unsigned pos);
    return pos == 0;
  endfunction

  function automatic logic is_last_slot(input int unsigned pos,
                                        input int unsigned frame_len);
    return pos == frame_len - 1;
  endfunction

endpackage

// File: rtl/frame_position_counter.sv
module frame_position_counter #(
  parameter int FRAME_LEN = 64,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] pos_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] pos_q;

  assign wrap_o = step && (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (wrap_o) pos_q <= '0;
    else if (step)   pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/frame_slot_decoder.sv
module frame_slot_decoder
  import pattern_frame_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int DATA_W    = 8,
  parameter int GAP_FIRST = 24,
  parameter int GAP_LAST  = 40,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  pos,
  output logic              start_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic first_w, last_w, high_w;

  assign first_w = is_first_slot(int'(pos));
  assign last_w  = is_last_slot(int'(pos), FRAME_LEN);
  assign high_w  = level_is_high(int'(pos), GAP_FIRST, GAP_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      start_o <= first_w;
      done_o  <= last_w;
      data_o  <= high_w ? '1 : '0;
    end
  end
endmodule

// File: rtl/pattern_frame_gen.sv
module pattern_frame_gen #(
  parameter int FRAME_LEN = 64,
  parameter int DATA_W    = 8,
  parameter int GAP_FIRST = 24,
  parameter int GAP_LAST  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic              start_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic             step_w;
  logic             wrap_w;
  logic [CNT_W-1:0] pos_w;

  assign step_w = en && !rst;

  frame_position_counter #(.FRAME_LEN(FRAME_LEN)) i_counter (
    .clk   (clk),
    .rst   (rst),
    .step  (step_w),
    .pos_o (pos_w),
    .wrap_o(wrap_w)
  );

  frame_slot_decoder #(
    .FRAME_LEN(FRAME_LEN),
    .DATA_W   (DATA_W),
    .GAP_FIRST(GAP_FIRST),
    .GAP_LAST (GAP_LAST)
  ) i_decoder (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .pos    (pos_w),
    .start_o(start_o),
    .data_o (data_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/pattern_frame_gen_chk.sv
module pattern_frame_gen_chk #(
  parameter int FRAME_LEN = 64,
  parameter int DATA_W    = 8,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              start_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  pos,
  input logic              step,
  input logic              wrap
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  a_r1_pos_advances: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap) |=> (pos == $past(pos) + 1'b1));

  a_r1_pos_wraps: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (pos == '0));

  a_r1_wrap_at_last: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (pos == LAST_POS));

  a_r8_pos_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pos));

  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  a_r2_start_data_zero: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (data_o == '0) && !done_o);

  a_r5_two_levels: assert property (@(posedge clk) disable iff (rst)
    (data_o == '0) || (data_o == {DATA_W{1'b1}}));

  a_r6_done_then_start: assert property (@(posedge clk) disable iff (rst)
    (done_o && en) |=> start_o);

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> !start_o && !done_o && (data_o == '0) && (pos == '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !start_o && !done_o && (data_o == '0));
endmodule

bind pattern_frame_gen pattern_frame_gen_chk #(
  .FRAME_LEN(FRAME_LEN),
  .DATA_W   (DATA_W)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .start_o(start_o),
  .data_o (data_o),
  .done_o (done_o),
  .pos    (pos_w),
  .step   (step_w),
  .wrap   (wrap_w)
);

// File: tb/test_pattern_frame_gen.sv
module test_pattern_frame_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       start_o, done_o;
  logic [7:0] data_o;

  always #2 clk = ~clk;

  pattern_frame_gen i_pattern_frame_gen (
    .clk(clk), .rst(rst), .en(en),
    .start_o(start_o), .data_o(data_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model: integer position, expected outputs, requirement tag.
  int    ref_pos   = 0;
  bit    exp_start = 0;
  bit    exp_done  = 0;
  int    exp_data  = 0;
  string exp_tag   = "R7";
  bit    model_on  = 0;

  always @(posedge clk) begin
    if (rst) begin
      ref_pos = 0; exp_start = 0; exp_done = 0; exp_data = 0; exp_tag = "R7";
    end else if (!en) begin
      exp_start = 0; exp_done = 0; exp_data = 0; exp_tag = "R8";
    end else begin
      exp_start = (ref_pos == 0);
      exp_done  = (ref_pos == 63);
      if (ref_pos == 0)       begin exp_data = 0;   exp_tag = "R2"; end
      else if (ref_pos <= 23) begin exp_data = 255; exp_tag = "R3"; end
      else if (ref_pos <= 40) begin exp_data = 0;   exp_tag = "R4"; end
      else if (ref_pos <= 62) begin exp_data = 255; exp_tag = "R5"; end
      else                    begin exp_data = 255; exp_tag = "R6"; end
      ref_pos = (ref_pos + 1) % 64;
    end
    model_on = 1;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !finished) begin
      check(exp_tag, "start_o", int'(start_o), int'(exp_start));
      check(exp_tag, "data_o",  int'(data_o),  exp_data);
      check(exp_tag, "done_o",  int'(done_o),  int'(exp_done));
    end
  end

  // R1: spacing of start strobes during an uninterrupted run.
  bit steady = 0;
  int since_start = -1;
  always @(negedge clk) begin
    if (!steady) since_start = -1;
    else if (start_o) begin
      if (since_start >= 0) check("R1", "start spacing", since_start, 64);
      since_start = 1;
    end else if (since_start >= 0) since_start++;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cycles(3);                       // R7: reset holds outputs low
    #1 en = 1'b1;
    cycles(3);                       // R7: enable during reset still quiet
    #1 rst = 1'b0;
    steady = 1;
    cycles(64 * 3 + 5);              // R1..R6: back-to-back frames
    steady = 0;
    #1 en = 1'b0;                    // R8: pause at a plateau
    cycles(6);
    #1 en = 1'b1;
    cycles(20);                      // resume across the 23/24 boundary
    #1 en = 1'b0;
    cycles(3);
    #1 en = 1'b1;
    cycles(30);                      // across 40/41 boundary
    #1 rst = 1'b1;                   // R7: mid-frame reset
    cycles(2);
    #1 rst = 1'b0;
    cycles(70);                      // first enabled cycle is position 0
    #1 en = 1'b0;
    cycles(1);
    #1 en = 1'b1;
    cycles(70);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule